// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host side of a two-wire debug link. It takes one transfer command at a time and carries it out on the serial clock and data pins. The command holds a 4-bit request, a write word, a turnaround length, a forced-data flag and an idle count. The block sends the 8-bit request packet and releases the data line for the turnaround. It then samples the 3-bit acknowledge and moves the 32-bit data word with its parity bit. Last, it clocks the requested number of idle bits with the data line driven low. The block returns a 4-bit response code and, for a successful read, the read word.

The bit rate is set from outside through `tick_i`. Each serial bit takes two ticks: on the first tick the clock goes low and the host changes its output, and on the second tick the clock goes high and the host samples the target. Two controls, port-on and port-off, give the pins a known driven state or release them to high impedance.

Top module: `swd_host`

## Requirements
- R1: The request packet is 8 bits long and is sent LSB first in this order: start 1, req_i[0] (access port or debug port select), req_i[1] (read when 1), req_i[2], req_i[3], even parity over req_i, stop 0, park 1. The host changes swdio_o only while swclk_o is low.
- R2: Every turnaround lasts turn_i+1 serial clocks, and swdio_oe_o is low during it. One turnaround follows the request. A second one follows the acknowledge on a write, and follows the data phase on a read.
- R3: The acknowledge is sampled over 3 rising edges, LSB first. resp_o[2:0] equals the received bits, so OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. resp_o is valid when done_o is high.
- R4: On a write, the second turnaround is followed by 32 host-driven data bits, LSB first, and then an even parity bit.
- R5: On a read with acknowledge OK, the 32 data bits and the parity bit are sampled straight after the acknowledge. If the parity matches, rdata_o holds the word.
- R6: resp_o[3] is set when the acknowledge is not one of the three legal codes, or when a read with acknowledge OK has a parity mismatch. A read with bad parity returns rdata_o = 0.
- R7: Without force_data_i, an acknowledge other than OK skips the data phase. The host then runs one turnaround and the idle bits.
- R8: With force_data_i, the 33-bit data phase is clocked whatever the acknowledge. A read word received after an acknowledge other than OK is discarded: rdata_o = 0 and no parity error is flagged.
- R9: After the transfer, idle_i serial clocks follow with swdio_oe_o high and swdio_o low.
- R10: After reset the port is off and all three output enables are low. port_on_i sets the port on: swclk_oe_o, swdio_oe_o and nreset_oe_o go high, and swclk_o and nreset_o are high. port_off_i turns the port off and releases all three enables. port_off_i wins over port_on_i.
- R11: start_i is accepted only when busy_o is low and the port is on. busy_o stays high until the transfer ends. done_o pulses for exactly one cycle, and a start_i while busy has no effect.
- R12: The serial timing advances only on cycles with tick_i high. While tick_i is low, swclk_o and the bit position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate enable, two per serial bit |
| port_on_i | input | 1 | Drive the pins to their default state |
| port_off_i | input | 1 | Release all pins |
| turn_i | input | TRN_W | Turnaround length minus one |
| force_data_i | input | 1 | Clock the data phase whatever the acknowledge |
| start_i | input | 1 | Command valid |
| req_i | input | 4 | Request bits: port select, read, A2, A3 |
| wdata_i | input | DATA_W | Write word |
| idle_i | input | IDLE_W | Idle clocks after the transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the response is valid |
| resp_o | output | 4 | {error, FAULT, WAIT, OK} |
| rdata_o | output | DATA_W | Read word |
| swclk_o | output | 1 | Serial clock |
| swclk_oe_o | output | 1 | Serial clock drive enable |
| swdio_o | output | 1 | Serial data out |
| swdio_oe_o | output | 1 | Serial data drive enable |
| swdio_i | input | 1 | Serial data in |
| nreset_o | output | 1 | Target reset, active low |
| nreset_oe_o | output | 1 | Target reset drive enable |

## Verification
The assertions check the rules that must hold on every cycle. The host data changes only while the clock is low. The host never drives during the acknowledge or the read data. Nothing moves on cycles without a tick. done_o lasts one cycle, a clean response holds one legal code, and the pin enables follow port-on and port-off. Only the bench scenarios can show the serial content: the exact bit stream on each rising edge, the turnaround and idle lengths, and the choice between skipping and forcing the data phase. They also show the parity and illegal-code outcomes, and that a start during a transfer has no effect.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_TRN1, ST_ACK, ST_RDAT, ST_TRN2, ST_WDAT, ST_TAIL
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam int         REQ_LEN   = 8;

  // bit 0 goes out first: start, req[3:0], parity, stop, park
  function automatic logic [REQ_LEN-1:0] req_packet(input logic [3:0] req);
    return {1'b1, 1'b0, ^req, req, 1'b1};
  endfunction
endpackage

// File: rtl/swd_pins.sv
module swd_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic clk_line_i,
  input  logic drive_i,
  input  logic dio_i,
  output logic en_o,
  output logic swclk_o,
  output logic swclk_oe_o,
  output logic swdio_o,
  output logic swdio_oe_o,
  output logic nreset_o,
  output logic nreset_oe_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (off_i)   en_q <= 1'b0;
    else if (on_i)    en_q <= 1'b1;
  end

  assign en_o        = en_q;
  assign swclk_o     = clk_line_i;
  assign swclk_oe_o  = en_q;
  assign swdio_o     = dio_i;
  assign swdio_oe_o  = en_q & drive_i;
  assign nreset_o    = en_q;
  assign nreset_oe_o = en_q;

  AST_OFF_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> !swclk_oe_o && !swdio_oe_o && !nreset_oe_o); // R10
  AST_ON_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i && !off_i |=> swclk_oe_o && nreset_oe_o && nreset_o); // R10
endmodule

// File: rtl/swd_engine.sv
module swd_engine #(
  parameter int DATA_W = 32,
  parameter int IDLE_W = 8,
  parameter int TRN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [3:0]        req_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDLE_W-1:0] idle_i,
  input  logic [TRN_W-1:0]  turn_i,
  input  logic              force_i,
  input  logic              swdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [3:0]        resp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              swclk_o,
  output logic              drive_o,
  output logic              dio_o
);
  import swd_pkg::*;

  localparam int DPH_W = $clog2(DATA_W + 2);
  localparam int CNT_W = (IDLE_W > DPH_W) ? IDLE_W : DPH_W;

  swd_state_e          state_q;
  logic                phase_q, swclk_q, drive_q, dio_q, done_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [REQ_LEN-1:0]  pkt_q;
  logic [DATA_W:0]     wd_q, rx_q;
  logic [2:0]          ack_q;
  logic [3:0]          resp_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                rnw_q, force_q, wr_q;
  logic [TRN_W-1:0]    turn_q;
  logic [IDLE_W-1:0]   idle_q;

  logic [2:0]      ack_full;
  logic [DATA_W:0] rx_full;
  logic            ack_legal, data_go, last_turn, end_done, bit_drive, bit_val;
  swd_state_e      end_state;

  always_comb begin
    ack_full  = {swdio_i, ack_q[2:1]};
    rx_full   = {swdio_i, rx_q[DATA_W:1]};
    ack_legal = (ack_full == ACK_OK) || (ack_full == ACK_WAIT) || (ack_full == ACK_FAULT);
    data_go   = (ack_full == ACK_OK) || force_q;
    last_turn = (cnt_q == CNT_W'(turn_q));
    end_done  = (idle_q == '0);
    end_state = end_done ? ST_IDLE : ST_TAIL;
    bit_drive = 1'b0;
    bit_val   = dio_q;
    case (state_q)
      ST_REQ:  begin bit_drive = 1'b1; bit_val = pkt_q[0]; end
      ST_WDAT: begin bit_drive = 1'b1; bit_val = wd_q[0];  end
      ST_TAIL: begin bit_drive = 1'b1; bit_val = 1'b0;     end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      swclk_q <= 1'b1;
      drive_q <= 1'b1;
      dio_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      pkt_q   <= '0;
      wd_q    <= '0;
      rx_q    <= '0;
      ack_q   <= '0;
      resp_q  <= '0;
      rdata_q <= '0;
      rnw_q   <= 1'b0;
      force_q <= 1'b0;
      wr_q    <= 1'b0;
      turn_q  <= '0;
      idle_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        swclk_q <= 1'b1;
        drive_q <= 1'b1;
        dio_q   <= 1'b0;
        if (start_i && en_i) begin
          state_q <= ST_REQ;
          phase_q <= 1'b0;
          cnt_q   <= '0;
          pkt_q   <= req_packet(req_i);
          wd_q    <= {^wdata_i, wdata_i};
          rnw_q   <= req_i[1];
          force_q <= force_i;
          turn_q  <= turn_i;
          idle_q  <= idle_i;
        end
      end else if (tick_i) begin
        phase_q <= ~phase_q;
        if (!phase_q) begin
          swclk_q <= 1'b0;
          drive_q <= bit_drive;
          dio_q   <= bit_val;
        end else begin
          swclk_q <= 1'b1;
          cnt_q   <= cnt_q + CNT_W'(1);
          case (state_q)
            ST_REQ: begin
              pkt_q <= {1'b0, pkt_q[REQ_LEN-1:1]};
              if (cnt_q == CNT_W'(REQ_LEN - 1)) begin state_q <= ST_TRN1; cnt_q <= '0; end
            end
            ST_TRN1: if (last_turn) begin state_q <= ST_ACK; cnt_q <= '0; end
            ST_ACK: begin
              ack_q <= ack_full;
              if (cnt_q == CNT_W'(2)) begin
                cnt_q   <= '0;
                resp_q  <= {~ack_legal, ack_full};
                rdata_q <= '0;
                wr_q    <= data_go & ~rnw_q;
                state_q <= (data_go && rnw_q) ? ST_RDAT : ST_TRN2;
              end
            end
            ST_RDAT: begin
              rx_q <= rx_full;
              if (cnt_q == CNT_W'(DATA_W)) begin
                cnt_q   <= '0;
                state_q <= ST_TRN2;
                if (resp_q[2:0] == ACK_OK) begin
                  if (^rx_full) resp_q[3] <= 1'b1;
                  else          rdata_q   <= rx_full[DATA_W-1:0];
                end
              end
            end
            ST_TRN2: if (last_turn) begin
              cnt_q <= '0;
              if (wr_q) state_q <= ST_WDAT;
              else begin state_q <= end_state; done_q <= end_done; end
            end
            ST_WDAT: begin
              wd_q <= {1'b0, wd_q[DATA_W:1]};
              if (cnt_q == CNT_W'(DATA_W)) begin
                cnt_q   <= '0;
                state_q <= end_state;
                done_q  <= end_done;
              end
            end
            ST_TAIL: if (cnt_q == CNT_W'(idle_q) - CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign resp_o  = resp_q;
  assign rdata_o = rdata_q;
  assign swclk_o = swclk_q;
  assign drive_o = drive_q;
  assign dio_o   = dio_q;

  AST_DIO_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$stable(dio_q) |-> !swclk_q); // R1
  AST_RELEASED_SAMPLING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK || state_q == ST_RDAT) |-> !drive_q); // R2
  AST_CLEAN_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !resp_q[3] |-> $countones(resp_q[2:0]) == 1); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R11
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(turn_q) && $stable(idle_q) && $stable(rnw_q)); // R11
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(swclk_q) && $stable(cnt_q) && $stable(state_q)); // R12
endmodule

// File: rtl/swd_host.sv
module swd_host #(
  parameter int DATA_W = 32,
  parameter int IDLE_W = 8,
  parameter int TRN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              port_on_i,
  input  logic              port_off_i,
  input  logic [TRN_W-1:0]  turn_i,
  input  logic              force_data_i,
  input  logic              start_i,
  input  logic [3:0]        req_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDLE_W-1:0] idle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [3:0]        resp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              swclk_o,
  output logic              swclk_oe_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i,
  output logic              nreset_o,
  output logic              nreset_oe_o
);
  logic en, clk_line, drive, dio;

  swd_engine #(.DATA_W(DATA_W), .IDLE_W(IDLE_W), .TRN_W(TRN_W)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (en),
    .start_i (start_i),
    .req_i   (req_i),
    .wdata_i (wdata_i),
    .idle_i  (idle_i),
    .turn_i  (turn_i),
    .force_i (force_data_i),
    .swdio_i (swdio_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .resp_o  (resp_o),
    .rdata_o (rdata_o),
    .swclk_o (clk_line),
    .drive_o (drive),
    .dio_o   (dio)
  );

  swd_pins u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_i        (port_on_i),
    .off_i       (port_off_i),
    .clk_line_i  (clk_line),
    .drive_i     (drive),
    .dio_i       (dio),
    .en_o        (en),
    .swclk_o     (swclk_o),
    .swclk_oe_o  (swclk_oe_o),
    .swdio_o     (swdio_o),
    .swdio_oe_o  (swdio_oe_o),
    .nreset_o    (nreset_o),
    .nreset_oe_o (nreset_oe_o)
  );
endmodule

// File: tb/sim_swd_host.sv
`timescale 1ns/1ps
module sim_swd_host;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1, port_on = 1'b0, port_off = 1'b0, force_d = 1'b0, start = 1'b0;
  logic [1:0]  turn = '0;
  logic [3:0]  req = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  idle = '0;
  logic        busy, done, swclk, swclk_oe, swdio_o, swdio_oe, swdio_i, nreset, nreset_oe;
  logic [3:0]  resp;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cyc = 0, nrise = 0, n_exp = 0, tick_mode = 1;
  bit arm = 1'b0, prev_clk = 1'b1;
  bit rec_oe [512];
  bit rec_v  [512];
  bit exp_oe [512];
  bit exp_v  [512];
  bit exp_care [512];
  int exp_tag [512];
  bit rx_bits [512];

  always #10 clk = ~clk;

  swd_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .port_on_i(port_on), .port_off_i(port_off),
    .turn_i(turn), .force_data_i(force_d), .start_i(start), .req_i(req), .wdata_i(wdata),
    .idle_i(idle), .busy_o(busy), .done_o(done), .resp_o(resp), .rdata_o(rdata),
    .swclk_o(swclk), .swclk_oe_o(swclk_oe), .swdio_o(swdio_o), .swdio_oe_o(swdio_oe),
    .swdio_i(swdio_i), .nreset_o(nreset), .nreset_oe_o(nreset_oe)
  );

  always @(posedge clk) begin
    #2;
    case (tick_mode)
      0:       tick_i = 1'($urandom % 2);
      1:       tick_i = 1'b1;
      default: tick_i = 1'b0;
    endcase
  end

  // target model: records host bits at each rising edge, presents the next bit after it
  always @(negedge clk) begin
    if (arm) begin
      nrise = 0;
      swdio_i = rx_bits[0];
    end else if (swclk && !prev_clk) begin
      if (nrise < 512) begin rec_oe[nrise] = swdio_oe; rec_v[nrise] = swdio_o; end
      nrise++;
      swdio_i = rx_bits[nrise % 512];
    end
    prev_clk = swclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog expired: actual busy=%0b expected done", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit oe, input bit v, input bit care, input int tag, input bit rx);
    if (n_exp < 512) begin
      exp_oe[n_exp] = oe; exp_v[n_exp] = v; exp_care[n_exp] = care;
      exp_tag[n_exp] = tag; rx_bits[n_exp] = rx;
    end
    n_exp++;
  endtask

  task automatic run_xfer(input logic [3:0] rq, input int tn, input logic [2:0] ack, input bit frc,
                          input int idl, input logic [31:0] wd, input logic [31:0] rd,
                          input bit corrupt, input bit poke, input bit hold);
    logic [7:0]  pkt;
    logic [32:0] wfr, rfr;
    bit go, rnw, legal, ok_rd;
    logic [3:0]  exp_resp;
    logic [31:0] exp_rd;
    int bad;
    string tag;
    for (int i = 0; i < 512; i++) rx_bits[i] = 1'b0;
    n_exp = 0;
    pkt = {1'b1, 1'b0, ^rq, rq, 1'b1};                   // R1 packet layout
    wfr = {^wd, wd};
    rfr = {(^rd) ^ corrupt, rd};
    rnw = rq[1];
    go  = (ack == 3'b001) || frc;
    for (int k = 0; k < 8; k++) push(1'b1, pkt[k], 1'b1, 1, 1'b0);
    for (int k = 0; k <= tn; k++) push(1'b0, 1'b0, 1'b1, 2, 1'b0);
    for (int k = 0; k < 3; k++) push(1'b0, 1'b0, 1'b1, 3, ack[k]);
    if (go && rnw) begin
      for (int k = 0; k < 33; k++) push(1'b0, 1'b0, 1'b1, 5, rfr[k]);
      for (int k = 0; k <= tn; k++) push(1'b0, 1'b0, 1'b1, 2, 1'b0);
    end else if (go) begin
      for (int k = 0; k <= tn; k++) push(1'b0, 1'b0, 1'b1, 2, 1'b0);
      for (int k = 0; k < 33; k++) push(1'b1, wfr[k], 1'b1, 4, 1'b0);
    end else begin
      for (int k = 0; k <= tn; k++) push(1'b0, 1'b0, 1'b1, 7, 1'b0);
    end
    for (int k = 0; k < idl; k++) push(1'b1, 1'b0, 1'b1, 9, 1'b0);
    legal    = (ack == 3'b001) || (ack == 3'b010) || (ack == 3'b100);
    ok_rd    = rnw && (ack == 3'b001);
    exp_resp = {!legal || (ok_rd && corrupt), ack};
    exp_rd   = (ok_rd && !corrupt) ? rd : 32'h0;

    if (hold) tick_mode = 2;
    @(posedge clk); #2;
    req = rq; turn = 2'(tn); force_d = frc; idle = 8'(idl); wdata = wd;
    start = 1'b1; arm = 1'b1;
    @(posedge clk); #2;
    start = 1'b0; arm = 1'b0;
    if (hold) begin
      repeat (20) @(negedge clk);
      // R12: no tick, no progress
      chk(busy && swclk && nrise == 0, "R12", "hold without tick", {busy, swclk, 30'(nrise)}, {1'b1, 1'b1, 30'd0});
      tick_mode = 1;
    end
    if (poke) begin
      repeat (6) @(posedge clk); #2;
      req = ~rq; start = 1'b1;                            // R11: must be ignored
      @(posedge clk); #2;
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    tag = !legal ? "R6" : (ok_rd && corrupt) ? "R6" : "R3";
    chk(resp == exp_resp, tag, "response code", 64'(resp), 64'(exp_resp));
    tag = (frc && ack != 3'b001) ? "R8" : corrupt ? "R6" : "R5";
    chk(rdata == exp_rd, tag, "read word", 64'(rdata), 64'(exp_rd));
    @(negedge clk);
    chk(!done && !busy, "R11", "done single cycle", {done, busy}, 2'b00);
    chk(nrise == n_exp, (idl > 0) ? "R9" : "R7", "rising edge count", 64'(nrise), 64'(n_exp));
    bad = -1;
    for (int i = 0; i < n_exp && i < 512; i++)
      if (bad < 0 && exp_care[i] &&
          (rec_oe[i] != exp_oe[i] || (exp_oe[i] && rec_v[i] != exp_v[i]))) bad = i;
    if (bad >= 0)
      chk(1'b0, $sformatf("R%0d", exp_tag[bad]), $sformatf("bit %0d oe/value", bad),
          {rec_oe[bad], rec_v[bad]}, {exp_oe[bad], exp_v[bad]});
    else
      chk(1'b1, poke ? "R11" : "R1", "serial stream", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset leaves the port off
    chk(!swclk_oe && !swdio_oe && !nreset_oe && !busy && !done, "R10", "reset state",
        {swclk_oe, swdio_oe, nreset_oe, busy, done}, 5'b0);
    // R11: start while off is ignored
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && nrise == 0, "R11", "start while off", {busy, 8'(nrise)}, 9'b0);
    @(posedge clk); #2 port_on = 1'b1; port_off = 1'b1;
    @(posedge clk); #2 port_on = 1'b0; port_off = 1'b0;
    @(negedge clk);
    chk(!swclk_oe && !nreset_oe, "R10", "off wins over on", {swclk_oe, nreset_oe}, 2'b00);
    @(posedge clk); #2 port_on = 1'b1;
    @(posedge clk); #2 port_on = 1'b0;
    @(negedge clk);
    chk(swclk_oe && swdio_oe && nreset_oe && swclk && nreset, "R10", "port on levels",
        {swclk_oe, swdio_oe, nreset_oe, swclk, nreset}, 5'b11111);

    run_xfer(4'b0000, 0, 3'b001, 1'b0, 0, 32'hA5C3_0F81, 32'h0, 1'b0, 1'b0, 1'b0);  // R4 write
    run_xfer(4'b0110, 3, 3'b001, 1'b0, 5, 32'h0, 32'h1234_5678, 1'b0, 1'b0, 1'b0);  // R5 R2 R9
    run_xfer(4'b1011, 1, 3'b001, 1'b0, 2, 32'h0, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);  // R6 parity
    run_xfer(4'b0010, 2, 3'b010, 1'b0, 3, 32'h0, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0);  // R7 WAIT
    run_xfer(4'b0101, 0, 3'b100, 1'b1, 1, 32'h8000_0001, 32'h0, 1'b0, 1'b0, 1'b0);  // R8 forced write
    run_xfer(4'b0011, 1, 3'b010, 1'b1, 0, 32'h0, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0);  // R8 forced read
    run_xfer(4'b0100, 0, 3'b111, 1'b0, 0, 32'h7, 32'h0, 1'b0, 1'b0, 1'b0);          // R6 illegal ack
    run_xfer(4'b1000, 1, 3'b001, 1'b0, 4, 32'h5555_AAAA, 32'h0, 1'b0, 1'b1, 1'b0);  // R11 poke
    run_xfer(4'b0010, 0, 3'b001, 1'b0, 1, 32'h0, 32'hC001_CAFE, 1'b0, 1'b0, 1'b1);  // R12 hold

    for (int n = 0; n < 40; n++) begin
      logic [3:0] rq;
      logic [2:0] ak;
      int sel;
      rq  = 4'($urandom);
      sel = int'($urandom % 8);
      ak  = (sel == 4) ? 3'b010 : (sel == 5) ? 3'b100 : (sel == 6) ? 3'b000 : 3'b001;
      tick_mode = (n % 2 == 0) ? 0 : 1;                   // R12 random ticks
      run_xfer(rq, int'($urandom % 4), ak, 1'($urandom % 3 == 0), int'($urandom % 12),
               $urandom, $urandom, 1'($urandom % 4 == 0 && rq[1]), 1'b0, 1'b0);
    end
    tick_mode = 1;

    @(posedge clk); #2 port_off = 1'b1;
    @(posedge clk); #2 port_off = 1'b0;
    @(negedge clk);
    chk(!swclk_oe && !swdio_oe && !nreset_oe, "R10", "port off releases",
        {swclk_oe, swdio_oe, nreset_oe}, 3'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule